// File: doc/BRIEF.md
# Multi-Mode Timer Output Compare Unit

This block turns a free-running timer count into one output pin waveform. A 3-bit mode field picks the behaviour: one-shot edges in either direction, toggling on a match, a single high pulse or a repeating high pulse framed by two compare values, and edge-aligned PWM with or without a fault shutdown. Each mode sets its own pin level on entry and raises a one-cycle interrupt strobe on the edges it defines.

The timer, the register bank and the pin multiplexer sit outside. The block receives the timer count, a period-match strobe, the mode field, a primary and a secondary compare value, and an active-low fault input. All outputs are registered. They reflect the inputs sampled at the previous rising clock edge. A mode change is seen when `modeSel` differs from the mode held in the previous cycle. That cycle is a mode entry: the pin takes the new mode's initial level, one-shot completion and the fault latch are cleared, and no interrupt is raised.

Top module: `ocu_top`

## Requirements
- R1: While `rst` is high, `pinOut`, `pinDriven`, `irqPulse` and `faultLatched` are all 0 on the next edge.
- R2: With mode 000 the block releases the pin: `pinDriven` is 0 and `irqPulse` stays 0. In every other mode `pinDriven` is 1.
- R3: Mode 001 enters with the pin at 0. The pin rises when the timer equals the primary compare, with one `irqPulse` on that rise. It then stays high and raises no further interrupt until the mode is rewritten.
- R4: Mode 010 enters with the pin at 1. The pin falls on the first primary match, with one `irqPulse`. It then stays low with no further interrupt.
- R5: Mode 011 keeps the current pin level on entry. It inverts the pin on every primary match and raises `irqPulse` on each rise and each fall.
- R6: Mode 100 enters low. The pin goes high on a primary match and back low on the next secondary match, with `irqPulse` on that fall. After one pulse it holds low.
- R7: Mode 101 behaves like mode 100, but it repeats the high-on-primary, low-on-secondary pulse in every timer cycle, with `irqPulse` on each fall.
- R8: Modes 110 and 111 enter with the pin at 1 if the primary compare is non-zero and 0 if it is zero. The primary value becomes the active duty. No interrupt is raised from compare matches in these modes.
- R9: In PWM modes the secondary compare is a duty buffer. On a period-match strobe it is copied to the active duty, and the pin goes high if that value is non-zero, otherwise low. Between strobes the pin falls when the timer equals the active duty, and changes to the secondary value have no effect.
- R10: In mode 111, a falling edge on `faultN` (high in one cycle, low in the next) forces the pin low, raises `irqPulse` and sets `faultLatched`. This takes priority over a period-match strobe in the same cycle.
- R11: While `faultLatched` is set, the pin stays low through later period-match strobes. Only a mode rewrite clears the latch.
- R12: In mode 110, `faultN` has no effect on the pin, the interrupt or `faultLatched`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmrCount | input | TMR_W | Current timer count |
| periodHit | input | 1 | Timer period-match strobe (last count of a period) |
| modeSel | input | 3 | Mode field |
| cmpPri | input | TMR_W | Primary compare value |
| cmpSec | input | TMR_W | Secondary compare value / PWM duty buffer |
| faultN | input | 1 | Fault input, active low |
| pinOut | output | 1 | Pin level |
| pinDriven | output | 1 | 1 when the block owns the pin; 0 hands it to a general-purpose register |
| irqPulse | output | 1 | One-cycle interrupt strobe |
| faultLatched | output | 1 | Sticky fault flag in PWM with fault protection |

## Verification
In PWM with fault protection, the fault shutdown and the period-match duty reload can land in the same cycle. One wants to raise the pin and the other wants to pull it low. The bench drops `faultN` in exactly the cycle that carries `periodHit` with a non-zero buffered duty. It expects the pin low, one interrupt and the latch set on the next edge. It then confirms that later period strobes leave the pin low. A second collision is a duty match in the period's first cycle against the reload, and it is judged by the pin level after each period start.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

  typedef enum logic [2:0] {
    MODE_OFF     = 3'b000,
    MODE_ONE_HI  = 3'b001,
    MODE_ONE_LO  = 3'b010,
    MODE_TOGGLE  = 3'b011,
    MODE_DELAY   = 3'b100,
    MODE_PULSE   = 3'b101,
    MODE_PWM     = 3'b110,
    MODE_PWM_FLT = 3'b111
  } modeT;

  // compare results from datapath to control
  typedef struct packed {
    logic priHit;
    logic secHit;
    logic dutyHit;
    logic priNonZero;
    logic secNonZero;
    logic faultFall;
  } hitT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDutyPri;
    logic loadDutySec;
  } strobeT;

endpackage

// File: rtl/ocu_dpath.sv
module ocu_dpath
  import ocu_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TMR_W-1:0] tmrCount,
  input  logic [TMR_W-1:0] cmpPri,
  input  logic [TMR_W-1:0] cmpSec,
  input  logic             faultN,
  input  strobeT           strobes,
  output hitT              hits
);

  localparam logic [TMR_W-1:0] ZERO = '0;

  logic [TMR_W-1:0] dutyQ;
  logic             faultQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      dutyQ  <= ZERO;
      faultQ <= 1'b1;
    end else begin
      faultQ <= faultN;
      if (strobes.loadDutyPri)      dutyQ <= cmpPri;
      else if (strobes.loadDutySec) dutyQ <= cmpSec;
    end
  end

  always_comb begin
    hits.priHit     = (tmrCount == cmpPri);
    hits.secHit     = (tmrCount == cmpSec);
    hits.dutyHit    = (tmrCount == dutyQ);
    hits.priNonZero = (cmpPri != ZERO);
    hits.secNonZero = (cmpSec != ZERO);
    hits.faultFall  = faultQ & ~faultN;
  end

endmodule

// File: rtl/ocu_ctrl.sv
module ocu_ctrl
  import ocu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] modeSel,
  input  logic       periodHit,
  input  hitT        hits,
  output strobeT     strobes,
  output logic [2:0] modeCur,
  output logic       pinOut,
  output logic       pinDriven,
  output logic       irqPulse,
  output logic       faultLatched
);

  modeT modeQ, modeIn;
  logic pinQ, pinNext;
  logic doneQ, doneNext;
  logic latQ, latNext;
  logic irqQ, irqNext;
  logic entry;

  assign modeIn = modeT'(modeSel);
  assign entry  = (modeIn != modeQ);

  always_comb begin
    pinNext = pinQ;
    doneNext = doneQ;
    latNext = latQ;
    irqNext = 1'b0;
    strobes = '0;
    if (entry) begin
      doneNext = 1'b0;
      latNext  = 1'b0;
      case (modeIn)
        MODE_ONE_HI, MODE_DELAY, MODE_PULSE: pinNext = 1'b0;
        MODE_ONE_LO:                         pinNext = 1'b1;
        MODE_PWM, MODE_PWM_FLT: begin
          pinNext = hits.priNonZero;
          strobes.loadDutyPri = 1'b1;
        end
        default: pinNext = pinQ;
      endcase
    end else begin
      case (modeQ)
        MODE_ONE_HI, MODE_ONE_LO: begin
          if (!doneQ && hits.priHit) begin
            pinNext  = (modeQ == MODE_ONE_HI);
            irqNext  = 1'b1;
            doneNext = 1'b1;
          end
        end
        MODE_TOGGLE: begin
          if (hits.priHit) begin
            pinNext = ~pinQ;
            irqNext = 1'b1;
          end
        end
        MODE_DELAY, MODE_PULSE: begin
          if (!doneQ) begin
            if (!pinQ && hits.priHit) begin
              pinNext = 1'b1;
            end else if (pinQ && hits.secHit) begin
              pinNext = 1'b0;
              irqNext = 1'b1;
              doneNext = (modeQ == MODE_DELAY);
            end
          end
        end
        MODE_PWM, MODE_PWM_FLT: begin
          if (modeQ == MODE_PWM_FLT && (latQ || hits.faultFall)) begin
            pinNext = 1'b0;
            if (!latQ) begin
              irqNext = 1'b1;
              latNext = 1'b1;
            end
          end else if (periodHit) begin
            strobes.loadDutySec = 1'b1;
            pinNext = hits.secNonZero;
          end else if (hits.dutyHit) begin
            pinNext = 1'b0;
          end
        end
        default: pinNext = pinQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= MODE_OFF;
      pinQ  <= 1'b0;
      doneQ <= 1'b0;
      latQ  <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      modeQ <= modeIn;
      pinQ  <= pinNext;
      doneQ <= doneNext;
      latQ  <= latNext;
      irqQ  <= irqNext;
    end
  end

  assign modeCur      = modeQ;
  assign pinOut       = pinQ;
  assign pinDriven    = (modeQ != MODE_OFF);
  assign irqPulse     = irqQ;
  assign faultLatched = latQ;

endmodule

// File: rtl/ocu_top.sv
module ocu_top
  import ocu_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TMR_W-1:0] tmrCount,
  input  logic             periodHit,
  input  logic [2:0]       modeSel,
  input  logic [TMR_W-1:0] cmpPri,
  input  logic [TMR_W-1:0] cmpSec,
  input  logic             faultN,
  output logic             pinOut,
  output logic             pinDriven,
  output logic             irqPulse,
  output logic             faultLatched
);

  hitT        hitBus;
  strobeT     strobeBus;
  logic [2:0] modeCur;

  ocu_dpath #(.TMR_W(TMR_W)) i_dpath (
    .clk      (clk),
    .rst      (rst),
    .tmrCount (tmrCount),
    .cmpPri   (cmpPri),
    .cmpSec   (cmpSec),
    .faultN   (faultN),
    .strobes  (strobeBus),
    .hits     (hitBus)
  );

  ocu_ctrl i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .modeSel      (modeSel),
    .periodHit    (periodHit),
    .hits         (hitBus),
    .strobes      (strobeBus),
    .modeCur      (modeCur),
    .pinOut       (pinOut),
    .pinDriven    (pinDriven),
    .irqPulse     (irqPulse),
    .faultLatched (faultLatched)
  );

endmodule

// File: rtl/ocu_chk.sv
module ocu_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] modeSel,
  input logic [2:0] modeCur,
  input logic       faultFall,
  input logic       pinOut,
  input logic       pinDriven,
  input logic       irqPulse,
  input logic       faultLatched
);

  AST_OFF_RELEASES_PIN: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 3'b000) |=> !pinDriven); // R2

  AST_ONESHOT_HI_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (modeCur == 3'b001 && modeSel == 3'b001 && pinOut) |=> (pinOut && !irqPulse)); // R3

  AST_ONESHOT_LO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 3'b010 && modeCur != 3'b010) |=> pinOut); // R4

  AST_PWM_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 3'b110) |=> !irqPulse); // R8

  AST_FAULT_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
    (modeCur == 3'b111 && modeSel == 3'b111 && faultFall && !faultLatched)
      |=> (irqPulse && faultLatched && !pinOut)); // R10

  AST_LATCH_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
    faultLatched |-> !pinOut); // R11

endmodule

bind ocu_top ocu_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .modeSel      (modeSel),
  .modeCur      (modeCur),
  .faultFall    (hitBus.faultFall),
  .pinOut       (pinOut),
  .pinDriven    (pinDriven),
  .irqPulse     (irqPulse),
  .faultLatched (faultLatched)
);

// File: tb/test_ocu_top.sv
`timescale 1ns/1ps
module test_ocu_top;

  localparam int TMR_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [TMR_W-1:0] tmrCount = '0;
  logic             periodHit = 1'b0;
  logic [2:0]       modeSel = 3'b000;
  logic [TMR_W-1:0] cmpPri = '0;
  logic [TMR_W-1:0] cmpSec = '0;
  logic             faultN = 1'b1;
  logic             pinOut, pinDriven, irqPulse, faultLatched;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  ocu_top #(.TMR_W(TMR_W)) i_ocu_top (
    .clk(clk), .rst(rst), .tmrCount(tmrCount), .periodHit(periodHit),
    .modeSel(modeSel), .cmpPri(cmpPri), .cmpSec(cmpSec), .faultN(faultN),
    .pinOut(pinOut), .pinDriven(pinDriven), .irqPulse(irqPulse),
    .faultLatched(faultLatched)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(int t, bit per);
    tmrCount  = TMR_W'(t);
    periodHit = per;
    @(negedge clk);
  endtask

  task automatic expect2(string req, logic ePin, logic eIrq);
    chk(req, "pinOut", pinOut, ePin);
    chk(req, "irqPulse", irqPulse, eIrq);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(0, 0);
    step(0, 0);
    chk("R1", "pinOut", pinOut, 1'b0);
    chk("R1", "pinDriven", pinDriven, 1'b0);
    chk("R1", "irqPulse", irqPulse, 1'b0);
    chk("R1", "faultLatched", faultLatched, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_off();
    modeSel = 3'b000; cmpPri = 16'd3;
    for (int t = 0; t < 6; t++) begin
      step(t, 0);
      chk("R2", "pinDriven", pinDriven, 1'b0);
      chk("R2", "irqPulse", irqPulse, 1'b0);
    end
  endtask

  task automatic t_one_lo();
    modeSel = 3'b010; cmpPri = 16'd4;
    step(0, 0);
    expect2("R4", 1'b1, 1'b0);
    chk("R2", "pinDriven", pinDriven, 1'b1);
    for (int t = 1; t < 10; t++) begin
      step(t, t == 9);
      expect2("R4", t < 4, t == 4);
    end
    for (int t = 0; t < 10; t++) begin
      step(t, t == 9);
      expect2("R4", 1'b0, 1'b0);
    end
  endtask

  task automatic t_one_hi();
    modeSel = 3'b001; cmpPri = 16'd6;
    step(0, 0);
    expect2("R3", 1'b0, 1'b0);
    for (int t = 1; t < 10; t++) begin
      step(t, t == 9);
      expect2("R3", t >= 6, t == 6);
    end
    for (int t = 0; t < 10; t++) begin
      step(t, t == 9);
      expect2("R3", 1'b1, 1'b0);
    end
  endtask

  task automatic t_toggle();
    logic ePin = 1'b1;
    modeSel = 3'b011; cmpPri = 16'd2;
    step(0, 0);
    expect2("R5", 1'b1, 1'b0);
    for (int n = 0; n < 20; n++) begin
      int t = (n + 1) % 10;
      step(t, t == 9);
      if (t == 2) ePin = ~ePin;
      expect2("R5", ePin, t == 2);
    end
  endtask

  task automatic t_delay();
    modeSel = 3'b100; cmpPri = 16'd3; cmpSec = 16'd7;
    step(0, 0);
    expect2("R6", 1'b0, 1'b0);
    for (int t = 1; t < 10; t++) begin
      step(t, t == 9);
      expect2("R6", t >= 3 && t < 7, t == 7);
    end
    for (int t = 0; t < 10; t++) begin
      step(t, t == 9);
      expect2("R6", 1'b0, 1'b0);
    end
  endtask

  task automatic t_pulse();
    modeSel = 3'b101; cmpPri = 16'd3; cmpSec = 16'd7;
    step(0, 0);
    expect2("R7", 1'b0, 1'b0);
    for (int n = 0; n < 19; n++) begin
      int t = (n + 1) % 10;
      step(t, t == 9);
      expect2("R7", t >= 3 && t < 7, t == 7);
    end
  endtask

  task automatic t_pwm();
    modeSel = 3'b110; cmpPri = 16'd0; cmpSec = 16'd4;
    step(0, 0);
    expect2("R8", 1'b0, 1'b0);
    for (int t = 1; t < 9; t++) begin
      step(t, 0);
      expect2("R8", 1'b0, 1'b0);
    end
    step(9, 1);
    expect2("R9", 1'b1, 1'b0);
    cmpSec = 16'd7;
    for (int t = 0; t < 9; t++) begin
      faultN = (t == 2 || t == 3) ? 1'b0 : 1'b1;
      step(t, 0);
      expect2("R9", t < 4, 1'b0);
      chk("R12", "faultLatched", faultLatched, 1'b0);
    end
    faultN = 1'b1;
    step(9, 1);
    expect2("R9", 1'b1, 1'b0);
    for (int t = 0; t < 9; t++) begin
      step(t, 0);
      expect2("R9", t < 7, 1'b0);
    end
    cmpSec = 16'd0;
    step(9, 1);
    expect2("R9", 1'b0, 1'b0);
  endtask

  task automatic t_fault();
    faultN = 1'b1;
    modeSel = 3'b111; cmpPri = 16'd5; cmpSec = 16'd5;
    step(0, 0);
    expect2("R8", 1'b1, 1'b0);
    chk("R11", "faultLatched", faultLatched, 1'b0);
    for (int t = 1; t < 9; t++) begin
      step(t, 0);
      expect2("R8", t < 5, 1'b0);
    end
    faultN = 1'b0;
    step(9, 1);
    expect2("R10", 1'b0, 1'b1);
    chk("R10", "faultLatched", faultLatched, 1'b1);
    faultN = 1'b1;
    for (int n = 0; n < 10; n++) begin
      step(n, n == 9);
      expect2("R11", 1'b0, 1'b0);
      chk("R11", "faultLatched", faultLatched, 1'b1);
    end
    modeSel = 3'b110;
    step(0, 0);
    expect2("R11", 1'b1, 1'b0);
    chk("R11", "faultLatched", faultLatched, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got hung run expected completion");
      report();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_off();
    t_one_lo();
    t_one_hi();
    t_toggle();
    t_delay();
    t_pulse();
    t_pwm();
    t_fault();
    done = 1'b1;
    report();
    $finish;
  end

endmodule